// File: doc/BRIEF.md
# Channel-2 Block Transfer Launcher

The block runs one DMA channel's block transfer on request. Software programs a source address, a destination address, a byte length and the global operation word through a small register port, then writes the start strobe. The block accepts the request only when the operation word carries the expected enable pattern and the length is a whole number of 32-byte bursts. Once it has accepted a request, it sorts the destination into one of four classes. A FIFO window receives bursts at a fixed address. A memory window receives bursts at a remapped, advancing address. A discard window moves no data. Any other address is flagged as invalid.

Data is fetched from system RAM one 32-byte burst at a time with a request/response handshake. Each burst is then offered to the selected sink with valid/ready. When the last burst is taken, or at once for the discard and invalid classes, the block writes back the channel registers. The source and destination registers take the final source address, and the length, start and count registers are cleared. The enable bit of the channel-2 control word is cleared. A one-cycle interrupt pulse is raised at the same time.

Top module: `dma2_launch`

## Requirements
- R1: After reset the four channel control words (register words 8, 9, 10, 11 for channels 0..3) and the operation word (word 5) read 0, and busy_o, irq_o and bad_dst_o are low.
- R2: A start is accepted only if (operation word & 0x0000FFFF) == 0x00008201; bits above 15 are ignored. A refused start causes no busy, no RAM request, no sink write, no interrupt and no register change.
- R3: A start whose length (word 2) has any of bits 4..0 set is refused in the same way as in R2.
- R4: A destination in 0x10000000..0x10FFFFFF sends each burst to the FIFO port (fifo_valid_o). fifo_addr_o equals the programmed destination for every burst. Bursts arrive in source order, and mem_valid_o stays low.
- R5: A destination in 0x11000000..0x11FFFFE0 sends burst k to the memory port at ((dst & 0x00FFFFFF) | 0xA4000000) + 32*k.
- R6: A destination in 0x13000000..0x13FFFFE0 issues no RAM request and no sink write, and still completes with the source advanced by the length.
- R7: Any other destination moves no data and still completes. bad_dst_o pulses in the same cycle as irq_o.
- R8: Burst k reads RAM address (src + 32*k) mod 2^24. A transfer that runs past the RAM end continues from RAM address 0, with one request per 32 bytes in ascending order.
- R9: On completion, words 0 (source) and 1 (destination) hold src + len. Words 2 (length), 3 (start) and 4 (transfer count) read 0. The channel-2 control word (word 10) has bit 0 cleared and its other bits kept. irq_o is high for exactly one cycle, and busy_o is already low in that cycle.
- R10: Writing word 3 with bit 0 set is the start strobe. busy_o rises on the edge that accepts a start and stays high until the completion writes. Start strobes written while busy are ignored.
- R11: While a RAM request or sink write waits for ready, its address and data stay stable. With every ready held high, irq_o goes high after the edge 3n+1 edges after the start edge, where n = len/32 for the FIFO and memory windows and n = 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| ram_req_valid_o | output | 1 | RAM burst read request valid |
| ram_req_ready_i | input | 1 | RAM accepts the request |
| ram_req_addr_o | output | RAM_AW | RAM byte address of the burst |
| ram_rsp_valid_i | input | 1 | RAM burst data valid |
| ram_rsp_data_i | input | 8*BURST_B | RAM burst data |
| wr_data_o | output | 8*BURST_B | Burst data toward both sinks |
| fifo_valid_o | output | 1 | FIFO sink write valid |
| fifo_ready_i | input | 1 | FIFO sink ready |
| fifo_addr_o | output | 32 | FIFO sink address |
| mem_valid_o | output | 1 | Memory sink write valid |
| mem_ready_i | input | 1 | Memory sink ready |
| mem_addr_o | output | 32 | Memory sink byte address |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Completion interrupt pulse |
| bad_dst_o | output | 1 | Invalid destination pulse, with irq_o |

## Verification
Each burst takes three edges when all readies are high: request, response capture and sink write. The interrupt therefore lands 3n+1 edges after the accepting edge. The bench counts edges and compares that distance exactly in the unstalled cases. Under sink backpressure it checks only order, addresses and data, collected at the falling edge before the handshake edge. Register write-back values are read one cycle after the interrupt is seen, and refusals are judged after a 20-cycle quiet window.

// File: rtl/dma2l_pkg.sv
package dma2l_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {WIN_FIFO, WIN_MEM, WIN_DROP, WIN_BAD} win_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RREQ, ST_RDAT, ST_WRT, ST_FIN} st_e;

  localparam logic [3:0] RA_SRC  = 4'd0;
  localparam logic [3:0] RA_DST  = 4'd1;
  localparam logic [3:0] RA_LEN  = 4'd2;
  localparam logic [3:0] RA_GO   = 4'd3;
  localparam logic [3:0] RA_XCNT = 4'd4;
  localparam logic [3:0] RA_OPER = 4'd5;
  localparam logic [3:0] RA_CTRL = 4'd8;

  localparam logic [REG_W-1:0] FIFO_LO    = 32'h1000_0000;
  localparam logic [REG_W-1:0] FIFO_HI    = 32'h10FF_FFFF;
  localparam logic [REG_W-1:0] MEM_LO     = 32'h1100_0000;
  localparam logic [REG_W-1:0] MEM_HI     = 32'h11FF_FFE0;
  localparam logic [REG_W-1:0] DROP_LO    = 32'h1300_0000;
  localparam logic [REG_W-1:0] DROP_HI    = 32'h13FF_FFE0;
  localparam logic [REG_W-1:0] REMAP_KEEP = 32'h00FF_FFFF;
  localparam logic [REG_W-1:0] REMAP_BASE = 32'hA400_0000;
endpackage

// File: rtl/dma2l_win_dec.sv
module dma2l_win_dec
  import dma2l_pkg::*;
(
  input  logic [REG_W-1:0] dst_i,
  output win_e             win_o,
  output logic [REG_W-1:0] remap_o
);
  logic in_fifo, in_mem, in_drop;

  assign in_fifo = (dst_i >= FIFO_LO) && (dst_i <= FIFO_HI);
  assign in_mem  = (dst_i >= MEM_LO)  && (dst_i <= MEM_HI);
  assign in_drop = (dst_i >= DROP_LO) && (dst_i <= DROP_HI);

  always_comb begin
    if (in_fifo)      win_o = WIN_FIFO;
    else if (in_mem)  win_o = WIN_MEM;
    else if (in_drop) win_o = WIN_DROP;
    else              win_o = WIN_BAD;
  end

  assign remap_o = (dst_i & REMAP_KEEP) | REMAP_BASE;
endmodule

// File: rtl/dma2l_regs.sv
module dma2l_regs
  import dma2l_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [REG_W-1:0] fin_src_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] src_o,
  output logic [REG_W-1:0] dst_o,
  output logic [REG_W-1:0] len_o,
  output logic [REG_W-1:0] oper_o,
  output logic             go_o
);
  logic [REG_W-1:0] src_q, dst_q, len_q, go_q, xcnt_q, oper_q;
  logic [REG_W-1:0] ctrl_rd [NCH];

  function automatic logic hit(input logic [3:0] a);
    return we_i && (addr_i == a);
  endfunction

  assign go_o = hit(RA_GO) && wdata_i[0] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      go_q   <= '0;
      xcnt_q <= '0;
      oper_q <= '0;
    end else begin
      if (hit(RA_OPER)) oper_q <= wdata_i;
      if (done_i) begin
        src_q  <= fin_src_i;
        dst_q  <= fin_src_i;
        len_q  <= '0;
        go_q   <= '0;
        xcnt_q <= '0;
      end else begin
        if (hit(RA_SRC))  src_q  <= wdata_i;
        if (hit(RA_DST))  dst_q  <= wdata_i;
        if (hit(RA_LEN))  len_q  <= wdata_i;
        if (hit(RA_XCNT)) xcnt_q <= wdata_i;
        if (hit(RA_GO) && !busy_i) go_q <= wdata_i;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ctrl
    logic [REG_W-1:0] ctrl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q <= '0;
      end else if (done_i && (c == CH)) begin
        ctrl_q <= {ctrl_q[REG_W-1:1], 1'b0};
      end else if (hit(RA_CTRL + 4'(c))) begin
        ctrl_q <= wdata_i;
      end
    end
    assign ctrl_rd[c] = ctrl_q;
  end

  always_comb begin
    unique case (addr_i)
      RA_SRC:  rdata_o = src_q;
      RA_DST:  rdata_o = dst_q;
      RA_LEN:  rdata_o = len_q;
      RA_GO:   rdata_o = go_q;
      RA_XCNT: rdata_o = xcnt_q;
      RA_OPER: rdata_o = oper_q;
      default: begin
        rdata_o = '0;
        for (int c = 0; c < NCH; c++)
          if (addr_i == RA_CTRL + 4'(c)) rdata_o = ctrl_rd[c];
      end
    endcase
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign len_o  = len_q;
  assign oper_o = oper_q;
endmodule

// File: rtl/dma2l_engine.sv
module dma2l_engine
  import dma2l_pkg::*;
#(
  parameter int               RAM_AW    = 24,
  parameter int               BURST_B   = 32,
  parameter logic [REG_W-1:0] OPER_MASK = 32'h0000_FFFF,
  parameter logic [REG_W-1:0] OPER_KEY  = 32'h0000_8201,
  localparam int              BW        = 8 * BURST_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REG_W-1:0]  src_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [REG_W-1:0]  len_i,
  input  logic [REG_W-1:0]  oper_i,
  output logic              ram_req_valid_o,
  input  logic              ram_req_ready_i,
  output logic [RAM_AW-1:0] ram_req_addr_o,
  input  logic              ram_rsp_valid_i,
  input  logic [BW-1:0]     ram_rsp_data_i,
  output logic [BW-1:0]     wr_data_o,
  output logic              fifo_valid_o,
  input  logic              fifo_ready_i,
  output logic [REG_W-1:0]  fifo_addr_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [REG_W-1:0]  mem_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [REG_W-1:0]  fin_src_o,
  output logic              irq_o,
  output logic              bad_dst_o
);
  localparam int               OFS  = $clog2(BURST_B);
  localparam logic [REG_W-1:0] STEP = REG_W'(BURST_B);

  win_e             win_d, win_q;
  logic [REG_W-1:0] remap_d;
  st_e              st_q;
  logic [REG_W-1:0] src_q, rem_q, adr_q;
  logic [BW-1:0]    buf_q;
  logic             irq_q, bad_q;
  logic             oper_ok, len_ok, accept, data_win, sink_rdy;

  dma2l_win_dec u_dec (
    .dst_i   (dst_i),
    .win_o   (win_d),
    .remap_o (remap_d)
  );

  assign oper_ok  = (oper_i & OPER_MASK) == OPER_KEY;
  assign len_ok   = len_i[OFS-1:0] == '0;
  assign accept   = start_i && oper_ok && len_ok && (st_q == ST_IDLE);
  assign data_win = (win_d == WIN_FIFO) || (win_d == WIN_MEM);
  assign sink_rdy = (win_q == WIN_FIFO) ? fifo_ready_i : mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      src_q <= '0;
      rem_q <= '0;
      adr_q <= '0;
      win_q <= WIN_BAD;
      buf_q <= '0;
      irq_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      irq_q <= (st_q == ST_FIN);
      bad_q <= (st_q == ST_FIN) && (win_q == WIN_BAD);
      case (st_q)
        ST_IDLE: if (accept) begin
          src_q <= src_i;
          rem_q <= len_i;
          win_q <= win_d;
          adr_q <= (win_d == WIN_MEM) ? remap_d : dst_i;
          st_q  <= (data_win && (len_i != '0)) ? ST_RREQ : ST_FIN;
        end
        ST_RREQ: if (ram_req_ready_i) st_q <= ST_RDAT;
        ST_RDAT: if (ram_rsp_valid_i) begin
          buf_q <= ram_rsp_data_i;
          st_q  <= ST_WRT;
        end
        ST_WRT: if (sink_rdy) begin
          src_q <= src_q + STEP;
          rem_q <= rem_q - STEP;
          if (win_q == WIN_MEM) adr_q <= adr_q + STEP;
          st_q  <= (rem_q == STEP) ? ST_FIN : ST_RREQ;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ram_req_valid_o = (st_q == ST_RREQ);
  assign ram_req_addr_o  = src_q[RAM_AW-1:0];
  assign wr_data_o       = buf_q;
  assign fifo_valid_o    = (st_q == ST_WRT) && (win_q == WIN_FIFO);
  assign mem_valid_o     = (st_q == ST_WRT) && (win_q == WIN_MEM);
  assign fifo_addr_o     = adr_q;
  assign mem_addr_o      = adr_q;
  assign busy_o          = (st_q != ST_IDLE);
  assign done_o          = (st_q == ST_FIN);
  // rem is 0 after data windows and the full length otherwise
  assign fin_src_o       = src_q + rem_q;
  assign irq_o           = irq_q;
  assign bad_dst_o       = bad_q;
endmodule

// File: rtl/dma2_launch.sv
module dma2_launch
  import dma2l_pkg::*;
#(
  parameter int               RAM_AW    = 24,
  parameter int               BURST_B   = 32,
  parameter int               NCH       = 4,
  parameter int               CH        = 2,
  parameter logic [REG_W-1:0] OPER_MASK = 32'h0000_FFFF,
  parameter logic [REG_W-1:0] OPER_KEY  = 32'h0000_8201,
  localparam int              BW        = 8 * BURST_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              ram_req_valid_o,
  input  logic              ram_req_ready_i,
  output logic [RAM_AW-1:0] ram_req_addr_o,
  input  logic              ram_rsp_valid_i,
  input  logic [BW-1:0]     ram_rsp_data_i,
  output logic [BW-1:0]     wr_data_o,
  output logic              fifo_valid_o,
  input  logic              fifo_ready_i,
  output logic [31:0]       fifo_addr_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [31:0]       mem_addr_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              bad_dst_o
);
  logic [REG_W-1:0] src, dst, len, oper, fin_src;
  logic             go, done;

  dma2l_regs #(.NCH(NCH), .CH(CH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy_o),
    .done_i    (done),
    .fin_src_i (fin_src),
    .rdata_o   (reg_rdata_o),
    .src_o     (src),
    .dst_o     (dst),
    .len_o     (len),
    .oper_o    (oper),
    .go_o      (go)
  );

  dma2l_engine #(
    .RAM_AW(RAM_AW), .BURST_B(BURST_B), .OPER_MASK(OPER_MASK), .OPER_KEY(OPER_KEY)
  ) u_eng (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (go),
    .src_i           (src),
    .dst_i           (dst),
    .len_i           (len),
    .oper_i          (oper),
    .ram_req_valid_o (ram_req_valid_o),
    .ram_req_ready_i (ram_req_ready_i),
    .ram_req_addr_o  (ram_req_addr_o),
    .ram_rsp_valid_i (ram_rsp_valid_i),
    .ram_rsp_data_i  (ram_rsp_data_i),
    .wr_data_o       (wr_data_o),
    .fifo_valid_o    (fifo_valid_o),
    .fifo_ready_i    (fifo_ready_i),
    .fifo_addr_o     (fifo_addr_o),
    .mem_valid_o     (mem_valid_o),
    .mem_ready_i     (mem_ready_i),
    .mem_addr_o      (mem_addr_o),
    .busy_o          (busy_o),
    .done_o          (done),
    .fin_src_o       (fin_src),
    .irq_o           (irq_o),
    .bad_dst_o       (bad_dst_o)
  );
endmodule

// File: rtl/dma2_launch_chk.sv
module dma2_launch_chk #(
  parameter int RAM_AW = 24,
  parameter int BW     = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [3:0]        reg_addr_i,
  input logic              go_bit_i,
  input logic              ram_req_valid_o,
  input logic              ram_req_ready_i,
  input logic [RAM_AW-1:0] ram_req_addr_o,
  input logic [BW-1:0]     wr_data_o,
  input logic              fifo_valid_o,
  input logic              fifo_ready_i,
  input logic [31:0]       fifo_addr_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [31:0]       mem_addr_o,
  input logic              busy_o,
  input logic              irq_o,
  input logic              bad_dst_o
);
  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o);

  assert_one_sink_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_valid_o && mem_valid_o));

  assert_fifo_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_valid_o && !fifo_ready_i |=> fifo_valid_o && $stable(fifo_addr_o) && $stable(wr_data_o));

  assert_mem_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(wr_data_o));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_req_valid_o && !ram_req_ready_i |=> ram_req_valid_o && $stable(ram_req_addr_o));

  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(reg_we_i && (reg_addr_i == 4'd3) && go_bit_i));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(fifo_valid_o || mem_valid_o || ram_req_valid_o));

  assert_bad_with_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_dst_o |-> irq_o);
endmodule

bind dma2_launch dma2_launch_chk #(.RAM_AW(RAM_AW), .BW(8 * BURST_B)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_we_i        (reg_we_i),
  .reg_addr_i      (reg_addr_i),
  .go_bit_i        (reg_wdata_i[0]),
  .ram_req_valid_o (ram_req_valid_o),
  .ram_req_ready_i (ram_req_ready_i),
  .ram_req_addr_o  (ram_req_addr_o),
  .wr_data_o       (wr_data_o),
  .fifo_valid_o    (fifo_valid_o),
  .fifo_ready_i    (fifo_ready_i),
  .fifo_addr_o     (fifo_addr_o),
  .mem_valid_o     (mem_valid_o),
  .mem_ready_i     (mem_ready_i),
  .mem_addr_o      (mem_addr_o),
  .busy_o          (busy_o),
  .irq_o           (irq_o),
  .bad_dst_o       (bad_dst_o)
);

// File: tb/sim_dma2_launch.sv
`timescale 1ns/1ps
module sim_dma2_launch;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic reg_we = 0; logic [3:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic ram_req_valid, ram_req_ready = 1, ram_rsp_valid = 0;
  logic [23:0] ram_req_addr; logic [255:0] ram_rsp_data = '0, wr_data;
  logic fifo_valid, fifo_ready = 1, mem_valid, mem_ready = 1;
  logic [31:0] fifo_addr, mem_addr;
  logic busy, irq, bad_dst;

  dma2_launch u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ram_req_valid_o(ram_req_valid), .ram_req_ready_i(ram_req_ready),
    .ram_req_addr_o(ram_req_addr), .ram_rsp_valid_i(ram_rsp_valid),
    .ram_rsp_data_i(ram_rsp_data), .wr_data_o(wr_data),
    .fifo_valid_o(fifo_valid), .fifo_ready_i(fifo_ready), .fifo_addr_o(fifo_addr),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .busy_o(busy), .irq_o(irq), .bad_dst_o(bad_dst));

  int total = 0, fails = 0, cyc = 0;
  int ram_n, sk_n, irq_cnt = 0, bad_cnt = 0, busy_cnt, irq_edge, irq_busy = 0, last_edge;
  logic [23:0]  ram_log [16];
  logic [31:0]  sk_addr [16];
  logic [255:0] sk_data [16];
  logic         sk_mem  [16];
  logic pend = 0; logic [23:0] addr_l; bit stall = 0;

  function automatic logic [255:0] pat(input logic [23:0] a);
    return {8{8'h5A, a}};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // RAM model, sink model and monitors, all at the falling edge
  always @(negedge clk) begin
    ram_rsp_valid = 1'b0;
    if (pend) begin ram_rsp_valid = 1'b1; ram_rsp_data = pat(addr_l); pend = 0; end
    if (ram_req_valid && ram_req_ready) begin
      pend = 1; addr_l = ram_req_addr;
      if (ram_n < 16) ram_log[ram_n] = ram_req_addr;
      ram_n++;
    end
    fifo_ready = stall ? (cyc % 2 == 0) : 1'b1;
    mem_ready  = stall ? (cyc % 3 != 0) : 1'b1;
    if ((fifo_valid && fifo_ready) || (mem_valid && mem_ready)) begin
      if (sk_n < 16) begin
        sk_mem[sk_n]  = mem_valid;
        sk_addr[sk_n] = mem_valid ? mem_addr : fifo_addr;
        sk_data[sk_n] = wr_data;
      end
      sk_n++;
    end
    if (irq) begin irq_cnt++; irq_edge = cyc; if (busy) irq_busy++; end
    if (bad_dst) bad_cnt++;
    if (busy) busy_cnt++;
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2 reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2 reg_we = 0; last_edge = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #2 reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic clr;
    ram_n = 0; sk_n = 0; busy_cnt = 0;
  endtask

  task automatic launch(input logic [31:0] src, dst, len, oper, output int s_edge);
    wr(5, oper); wr(0, src); wr(1, dst); wr(2, len); wr(4, 32'h77); wr(10, 32'h5);
    clr(); wr(3, 32'h1); s_edge = last_edge;
  endtask

  task automatic wait_irq(input int c0);
    while (irq_cnt == c0) @(posedge clk);
    @(posedge clk); #2;
  endtask

  task automatic check_done(input string tag, input logic [31:0] fin);
    logic [31:0] v;
    rd(0, v); chk({tag, " R9 src reg"}, v, fin);
    rd(1, v); chk({tag, " R9 dst reg"}, v, fin);
    rd(2, v); chk({tag, " R9 len reg"}, v, 0);
    rd(3, v); chk({tag, " R9 start reg"}, v, 0);
    rd(4, v); chk({tag, " R9 count reg"}, v, 0);
    rd(10, v); chk({tag, " R9 ctrl2"}, v, 32'h4);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 8; i < 12; i++) begin rd(4'(i), v); chk("R1 ctrl word", v, 0); end
    rd(5, v); chk("R1 oper word", v, 0);
    chk("R1 busy/irq/bad", {busy, irq, bad_dst}, 0);
  endtask

  task automatic t_fifo;
    int s; int c0 = irq_cnt; logic [31:0] v;
    wr(8, 32'h33);
    launch(32'h0C00_0100, 32'h10FF_FFFF, 96, 32'h8201, s);
    #1 chk("R10 busy after accept", busy, 1);
    wait_irq(c0);
    chk("R11 irq latency fifo", irq_edge - s, 10);
    chk("R4 burst count", sk_n, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R4 fifo sink", sk_mem[k], 0);
      chk("R4 fifo addr fixed", sk_addr[k], 32'h10FF_FFFF);
      chk("R4 data order", sk_data[k], pat(24'h000100 + 24'(32 * k)));
      chk("R8 ram addr", ram_log[k], 24'h000100 + 24'(32 * k));
    end
    chk("R9 busy low at irq", irq_busy, 0);
    check_done("fifo", 32'h0C00_0160);
    rd(8, v); chk("R9 ctrl0 untouched", v, 32'h33);
  endtask

  task automatic t_mem;
    int s; int c0 = irq_cnt;
    stall = 1;
    launch(32'h0000_0400, 32'h1112_3440, 64, 32'hABCD_8201, s);
    wait_irq(c0);
    stall = 0;
    chk("R2 high oper bits masked, count", sk_n, 2);
    for (int k = 0; k < 2; k++) begin
      chk("R5 mem sink", sk_mem[k], 1);
      chk("R5 mem addr", sk_addr[k], 32'hA412_3440 + 32 * k);
      chk("R5 data", sk_data[k], pat(24'h000400 + 24'(32 * k)));
    end
    check_done("mem", 32'h0000_0440);
  endtask

  task automatic t_wrap;
    int s; int c0 = irq_cnt;
    logic [23:0] exp_a [4] = '{24'hFFFFC0, 24'hFFFFE0, 24'h000000, 24'h000020};
    launch(32'h05FF_FFC0, 32'h1000_0000, 128, 32'h8201, s);
    wait_irq(c0);
    chk("R8 request count", ram_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R8 wrap addr", ram_log[k], exp_a[k]);
      chk("R8 wrap data", sk_data[k], pat(exp_a[k]));
    end
    chk("R11 irq latency wrap", irq_edge - s, 13);
    check_done("wrap", 32'h0600_0040);
  endtask

  task automatic t_drop;
    int s; int c0 = irq_cnt; int b0 = bad_cnt;
    launch(32'h0000_0100, 32'h13FF_FFE0, 32'h40, 32'h8201, s);
    wait_irq(c0);
    chk("R6 no ram reads", ram_n, 0);
    chk("R6 no sink writes", sk_n, 0);
    chk("R11 irq latency drop", irq_edge - s, 1);
    chk("R6 not flagged bad", bad_cnt - b0, 0);
    check_done("drop", 32'h0000_0140);
  endtask

  task automatic t_bad(input logic [31:0] dst);
    int s; int c0 = irq_cnt; int b0 = bad_cnt;
    launch(32'h0000_2000, dst, 32'h20, 32'h8201, s);
    wait_irq(c0);
    chk("R7 no data moved", ram_n + sk_n, 0);
    chk("R7 bad pulse", bad_cnt - b0, 1);
    check_done("bad", 32'h0000_2020);
  endtask

  task automatic t_reject(input string tag, input logic [31:0] len, oper);
    int s; int c0 = irq_cnt; logic [31:0] v;
    launch(32'h0000_3000, 32'h1000_0000, len, oper, s);
    repeat (20) @(posedge clk);
    #2;
    chk({tag, " no busy"}, busy_cnt, 0);
    chk({tag, " no irq"}, irq_cnt - c0, 0);
    chk({tag, " no ram"}, ram_n + sk_n, 0);
    rd(0, v); chk({tag, " src kept"}, v, 32'h0000_3000);
  endtask

  task automatic t_busy;
    int s; int c0 = irq_cnt; logic [31:0] v;
    stall = 1;
    launch(32'h0000_5000, 32'h1000_0040, 64, 32'h8201, s);
    @(posedge clk); #2 chk("R10 busy mid transfer", busy, 1);
    wr(3, 32'h1);
    wait_irq(c0);
    stall = 0;
    repeat (20) @(posedge clk);
    #2;
    chk("R10 single completion", irq_cnt - c0, 1);
    chk("R10 bursts of one transfer", ram_n, 2);
    chk("R10 idle after", busy, 0);
    rd(3, v); chk("R10 start reg cleared", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_fifo();
    t_mem();
    t_wrap();
    t_drop();
    t_bad(32'h11FF_FFE1);
    t_bad(32'h1200_0000);
    t_reject("R2 oper mismatch", 32'h40, 32'h0000_8200);
    t_reject("R3 len low bits", 32'h30, 32'h0000_8201);
    t_reject("R3 len odd", 32'h21, 32'h0000_8201);
    t_busy();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule